// File: doc/BRIEF.md
# Multi-Channel Timer Output Controller

This block turns per-channel timer event pulses into registered output levels for a group of up to eight timer channels. Each channel has one mode bit. In toggle mode the channel's own event flips its level. In combination mode another channel, chosen as its master, raises the level with its event, and the channel's own event lowers it again. This lets two counters together shape a pulse or a PWM edge pair.

A small write port reaches two targets. The first is the mode word, which can be written as 16 bits or as its low byte only. The second is the level flip-flops, which can be preset directly while a channel's output enable is low. Output enables and master selections are static configuration inputs. The counters that produce the events sit outside this block.

Top module: `tmr_out_ctrl`

## Requirements
- R1: After reset, `mode_rdata` reads 0x0000, so every channel is in toggle mode, and every bit of `out_lvl` is 0.
- R2: With `out_en[q]`=1 and mode bit q=0, a one-cycle pulse on `tmr_evt[q]` inverts `out_lvl[q]` at the next rising clock edge. Without an event the level holds.
- R3: With `out_en[q]`=1 and mode bit q=1, an event on the master channel of q sets `out_lvl[q]` to 1 at the next edge. A repeated master event keeps it at 1 and does not toggle it.
- R4: With `out_en[q]`=1 and mode bit q=1, an event on channel q itself clears `out_lvl[q]` to 0 at the next edge.
- R5: In combination mode, when the master event and the channel's own event arrive in the same cycle, the level is cleared to 0.
- R6: While `out_en[q]`=0, no event on any channel changes `out_lvl[q]`.
- R7: A write with `bus_wr`=1, `bus_tgt`=0 and `bus_byte`=0 loads `bus_wdata[7:0]` into mode bits 7..0, where bit q is the mode of channel q. Bits 15..8 of `mode_rdata` always read 0.
- R8: A mode write with `bus_byte`=1 loads only `bus_wdata[7:0]` and ignores `bus_wdata[15:8]`, which still read back as 0.
- R9: A write with `bus_wr`=1 and `bus_tgt`=1 loads `bus_wdata[q]` into `out_lvl[q]` for each channel with `out_en[q]`=0. Channels with `out_en[q]`=1 are left unchanged by it.
- R10: The master of channel q (q>=1) is the channel whose index is held in `mst_sel[3q+2:3q]`. Channel 0 has no master: its field is ignored and nothing ever sets it in combination mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_tgt | input | 1 | Write target: 0 mode word, 1 level preset |
| bus_byte | input | 1 | 1 selects a low-byte-only mode write |
| bus_wdata | input | 16 | Write data |
| mode_rdata | output | 16 | Mode word read value, upper byte zero |
| tmr_evt | input | NCH | One-cycle event pulse per channel |
| out_en | input | NCH | Output enable per channel |
| mst_sel | input | 3*NCH | Master channel index per channel, 3 bits each |
| out_lvl | output | NCH | Registered output level per channel |

## Verification
The hardest case to reach is a combination-mode channel whose master event and own event land in the same cycle. This has to happen while the level is already 1, because a clear from 0 shows nothing. The stimulus first raises the level with a lone master pulse, then fires both pulses in one cycle. It also remaps a slave to a different master and then checks that the old master's event no longer raises it. A partial-enable preset confirms that a level write reaches only the disabled channels.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
    localparam int REG_W  = 16;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = 3;

    typedef enum logic {
        OUT_TOGGLE  = 1'b0,
        OUT_COMBINE = 1'b1
    } out_mode_e;

    typedef enum logic {
        TGT_MODE  = 1'b0,
        TGT_LEVEL = 1'b1
    } wr_tgt_e;

    typedef struct packed {
        logic lvl;
    } chan_st_t;
endpackage

// File: rtl/tmo_mode_reg.sv
module tmo_mode_reg
    import tmo_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_byte,
    input  logic [REG_W-1:0] wr_data,
    output logic [NCH-1:0]   mode,
    output logic [REG_W-1:0] rd_data
);
    typedef struct packed {
        logic [NCH-1:0] bits;
    } mode_st_t;

    mode_st_t         st_d, st_q;
    logic [REG_W-1:0] img;
    logic             unused_img;

    // Byte access keeps the upper byte, which is reserved and held at zero.
    always_comb begin
        img  = wr_byte ? {{(REG_W-BYTE_W){1'b0}}, wr_data[BYTE_W-1:0]} : wr_data;
        st_d = st_q;
        if (wr_en) begin
            st_d.bits = img[NCH-1:0];
        end
    end

    assign unused_img = ^img[REG_W-1:NCH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode    = st_q.bits;
    assign rd_data = {{(REG_W-NCH){1'b0}}, st_q.bits};

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[NCH-1:0] == $past(wr_data[NCH-1:0])); // R7
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data)); // R8
endmodule

// File: rtl/tmo_channel.sv
module tmo_channel
    import tmo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic oe,
    input  logic mode,
    input  logic evt_own,
    input  logic evt_master,
    input  logic lvl_wr,
    input  logic lvl_wdata,
    output logic lvl
);
    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (oe) begin
            if (out_mode_e'(mode) == OUT_COMBINE) begin
                // Own event (clear) outranks the master event (set).
                if (evt_own) begin
                    st_d.lvl = 1'b0;
                end else if (evt_master) begin
                    st_d.lvl = 1'b1;
                end
            end else if (evt_own) begin
                st_d.lvl = ~st_q.lvl;
            end
        end else if (lvl_wr) begin
            st_d.lvl = lvl_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl = st_q.lvl;

    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && !mode && evt_own) |=> lvl != $past(lvl)); // R2
    AST_COMB_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && mode && evt_master && !evt_own) |=> lvl); // R3
    AST_COMB_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && mode && evt_own) |=> !lvl); // R4 R5
    AST_OE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe && !lvl_wr) |=> lvl == $past(lvl)); // R6
    AST_LVL_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe && lvl_wr) |=> lvl == $past(lvl_wdata)); // R9
endmodule

// File: rtl/tmr_out_ctrl.sv
module tmr_out_ctrl
    import tmo_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_tgt,
    input  logic                 bus_byte,
    input  logic [15:0]          bus_wdata,
    output logic [15:0]          mode_rdata,
    input  logic [NCH-1:0]       tmr_evt,
    input  logic [NCH-1:0]       out_en,
    input  logic [NCH*3-1:0]     mst_sel,
    output logic [NCH-1:0]       out_lvl
);
    localparam int NSLOT = 1 << IDX_W;

    logic [NCH-1:0]   mode;
    logic [NCH-1:0]   mst_evt;
    logic [NSLOT-1:0] evt_pad;
    logic             mode_wr;
    logic             lvl_wr;
    logic             unused_sel;

    assign mode_wr    = bus_wr && (wr_tgt_e'(bus_tgt) == TGT_MODE);
    assign lvl_wr     = bus_wr && (wr_tgt_e'(bus_tgt) == TGT_LEVEL);
    assign evt_pad    = NSLOT'(tmr_evt);
    assign unused_sel = ^mst_sel[IDX_W-1:0];

    tmo_mode_reg #(.NCH(NCH)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_wr),
        .wr_byte (bus_byte),
        .wr_data (bus_wdata),
        .mode    (mode),
        .rd_data (mode_rdata)
    );

    for (genvar q = 0; q < NCH; q++) begin : g_ch
        // R10: channel 0 never has a master.
        if (q == 0) begin : g_nomst
            assign mst_evt[q] = 1'b0;
        end else begin : g_mst
            assign mst_evt[q] = evt_pad[mst_sel[q*IDX_W +: IDX_W]];
        end

        tmo_channel u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .oe         (out_en[q]),
            .mode       (mode[q]),
            .evt_own    (tmr_evt[q]),
            .evt_master (mst_evt[q]),
            .lvl_wr     (lvl_wr),
            .lvl_wdata  (bus_wdata[q]),
            .lvl        (out_lvl[q])
        );
    end

    AST_CH0_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_evt[0] && out_en[0]) |=> !$rose(out_lvl[0]) || !mode[0]); // R10
endmodule

// File: tb/tmr_out_ctrl_test.sv
`timescale 1ns/1ps
module tmr_out_ctrl_test;
    localparam int NCH = 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            bus_wr, bus_tgt, bus_byte;
    logic [15:0]     bus_wdata;
    logic [15:0]     mode_rdata;
    logic [NCH-1:0]  tmr_evt, out_en, out_lvl;
    logic [NCH*3-1:0] mst_sel;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tmr_out_ctrl #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_tgt(bus_tgt),
        .bus_byte(bus_byte), .bus_wdata(bus_wdata), .mode_rdata(mode_rdata),
        .tmr_evt(tmr_evt), .out_en(out_en), .mst_sel(mst_sel), .out_lvl(out_lvl)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_wr = 0; bus_tgt = 0; bus_byte = 0; bus_wdata = '0;
        tmr_evt = '0; out_en = '0; mst_sel = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic tgt, input logic byt, input logic [15:0] d);
        bus_wr = 1'b1; bus_tgt = tgt; bus_byte = byt; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic pulse(input logic [NCH-1:0] m);
        tmr_evt = m;
        @(negedge clk);
        tmr_evt = '0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 mode", mode_rdata, 16'h0000);
        chk("R1 level", 16'(out_lvl), 16'h0000);
    endtask

    task automatic t_toggle();
        do_reset();
        out_en = 8'hFF;
        pulse(8'h01); chk("R2 first", 16'(out_lvl), 16'h0001);
        pulse(8'h01); chk("R2 second", 16'(out_lvl), 16'h0000);
        pulse(8'h0A); chk("R2 multi", 16'(out_lvl), 16'h000A);
        @(negedge clk); chk("R2 hold", 16'(out_lvl), 16'h000A);
    endtask

    task automatic t_words();
        do_reset();
        wr(1'b0, 1'b0, 16'hFF04); chk("R7 word", mode_rdata, 16'h0004);
        wr(1'b0, 1'b1, 16'hC381); chk("R8 byte", mode_rdata, 16'h0081);
    endtask

    task automatic t_combine();
        do_reset();
        out_en = 8'hFF;
        mst_sel[2*3 +: 3] = 3'd1;
        wr(1'b0, 1'b0, 16'h0004);
        pulse(8'h02); chk("R3 set", 16'(out_lvl), 16'h0006);
        pulse(8'h04); chk("R4 clear", 16'(out_lvl), 16'h0002);
        pulse(8'h02); chk("R3 set again", 16'(out_lvl), 16'h0004);
        pulse(8'h06); chk("R5 clear wins", 16'(out_lvl), 16'h0002);
        pulse(8'h02); chk("R3 from clear", 16'(out_lvl), 16'h0004);
        pulse(8'h02); chk("R3 no toggle", 16'(out_lvl), 16'h0006);
    endtask

    task automatic t_mapping();
        do_reset();
        out_en = 8'hFF;
        mst_sel[2*3 +: 3] = 3'd3;
        mst_sel[0 +: 3]   = 3'd5;
        wr(1'b0, 1'b0, 16'h0005);
        pulse(8'h02); chk("R10 old master", 16'(out_lvl), 16'h0002);
        pulse(8'h08); chk("R10 new master", 16'(out_lvl), 16'h000E);
        pulse(8'h20); chk("R10 ch0 no master", 16'(out_lvl), 16'h002E);
    endtask

    task automatic t_gate();
        do_reset();
        wr(1'b1, 1'b0, 16'h005A); chk("R9 preset", 16'(out_lvl), 16'h005A);
        pulse(8'hFF);             chk("R6 frozen", 16'(out_lvl), 16'h005A);
        out_en = 8'h0F;
        wr(1'b1, 1'b0, 16'h00FF); chk("R9 partial", 16'(out_lvl), 16'h00FA);
        pulse(8'hF0);             chk("R6 partial", 16'(out_lvl), 16'h00FA);
        pulse(8'h0F);             chk("R2 enabled half", 16'(out_lvl), 16'h00F5);
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_toggle();
        t_words();
        t_combine();
        t_mapping();
        t_gate();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule